// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic-logic unit built from a chain of identical one-bit slices. Each slice holds a full adder, a conditional inverter on its second operand and a small result selector. The selector picks bitwise AND, bitwise OR, the adder sum, or a "less" input. The carry ripples from the least significant slice to the most significant one. A three-bit operation code selects the function. Its top bit is a single negate control that both inverts every bit of operand B and supplies a carry of one into the bottom slice, so the same adder chain performs subtraction.

A signed compare reuses the subtract path. The most significant slice produces a "set" signal, which is its sum bit corrected by signed overflow. That signal is routed back into the "less" input of slice 0, and every other slice sees a constant zero on its "less" input. Alongside the result, the block reports a zero flag for equality tests, a signed overflow flag and the unsigned carry out of the top slice. Overflow is reported only as a flag. There is no trap and no status storage.

The block has no clock and no stream traffic, so it has no valid/ready handshake. Operands and code are plain inputs, and every output settles within the same cycle in which the inputs change.

Top module: `slice_alu`

## Requirements
- R1: Operation code 3'b000 gives res = opnd_a AND opnd_b, bit by bit.
- R2: Operation code 3'b001 gives res = opnd_a OR opnd_b, bit by bit.
- R3: Operation code 3'b010 gives res = (opnd_a + opnd_b) modulo 2^32. carry_out is bit 32 of the unsigned 33-bit sum.
- R4: Operation code 3'b110 gives res = (opnd_a - opnd_b) modulo 2^32. carry_out is 1 exactly when opnd_a >= opnd_b as unsigned values, meaning no borrow.
- R5: Operation code 3'b111 gives res bit 0 = 1 when opnd_a < opnd_b as signed two's-complement values, and res bits 31..1 = 0. The compare stays correct when the internal subtraction overflows.
- R6: zero_flag is 1 exactly when all 32 bits of res are 0, for every operation code.
- R7: For an add-path code (op_sel bit 2 = 0), ovf_flag is 1 exactly when both operands have the same sign and the 32-bit sum has the other sign. Operands of opposite sign never set it.
- R8: For a negate-path code (op_sel bit 2 = 1), ovf_flag is 1 exactly when the operands' signs differ and the 32-bit difference has a sign different from opnd_a.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 drive res to all zeros, so zero_flag is 1.
- R10: ovf_flag and carry_out are driven for every code. When op_sel bit 2 = 0 they follow the sum a + b, and when op_sel bit 2 = 1 they follow a - b. This includes the logic codes and the unused codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, inverted when op_sel bit 2 is set |
| op_sel | input | 3 | Operation code |
| res | output | 32 | Selected result |
| zero_flag | output | 1 | All result bits are zero |
| ovf_flag | output | 1 | Signed overflow of the adder chain |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The compare is driven with operand pairs whose difference overflows, such as the most negative value against a positive value. A design that took the raw sign of the difference would report the wrong ordering there. Pairs at the edges of the signed range check overflow in both directions. Mixed-sign adds confirm that overflow stays clear, and a flag built from the carry out alone would fail them. Subtracting equal values, and subtracting zero from zero, checks that carry_out follows the no-borrow rule and that zero_flag rises. The three unused codes are applied with operands that would give non-zero results, to catch a decoder that falls through to the adder or the logic paths.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 32;
  localparam int unsigned OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Low two code bits choose what a slice puts on its result pin.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  function automatic logic op_is_legal(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT);
  endfunction
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       neg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);
  logic b_eff;

  always_comb begin
    b_eff  = b_i ^ neg_i;
    sum_o  = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    unique case (slice_sel_e'(sel_i))
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             neg_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] less;
  logic             set_bit;

  assign carry[0] = neg_i;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less[i] = set_bit;
      end else begin : g_upper
        assign less[i] = 1'b0;
      end
      alu_bit_slice u_slice (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .neg_i  (neg_i),
        .cin_i  (carry[i]),
        .less_i (less[i]),
        .sel_i  (sel_i),
        .res_o  (res_o[i]),
        .sum_o  (sum[i]),
        .cout_o (carry[i+1])
      );
    end
  endgenerate

  // Overflow: carry into the top slice disagrees with carry out of it.
  assign ovf_o   = carry[MSB] ^ carry[WIDTH];
  assign cout_o  = carry[WIDTH];
  // Sign of the difference, corrected when the difference overflowed.
  assign set_bit = sum[MSB] ^ ovf_o;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = ~(|val_i);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
(
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [2:0]  op_sel,
  output logic [31:0] res,
  output logic        zero_flag,
  output logic        ovf_flag,
  output logic        carry_out
);
  logic [ALU_W-1:0] chain_res;
  logic             code_ok;

  alu_slice_chain #(.WIDTH(ALU_W)) u_chain (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .neg_i  (op_sel[2]),
    .sel_i  (op_sel[1:0]),
    .res_o  (chain_res),
    .ovf_o  (ovf_flag),
    .cout_o (carry_out)
  );

  assign code_ok = op_is_legal(op_sel);
  assign res     = code_ok ? chain_res : '0;

  alu_zero_detect #(.WIDTH(ALU_W)) u_zero (
    .val_i  (res),
    .zero_o (zero_flag)
  );
endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker (
  input logic [31:0] opnd_a,
  input logic [31:0] opnd_b,
  input logic [2:0]  op_sel,
  input logic [31:0] res,
  input logic        zero_flag,
  input logic        ovf_flag,
  input logic        carry_out
);
  always_comb begin
    assert_zero_match_R6: assert (zero_flag == (res == 32'd0))
      else $error("zero flag disagrees with result");
    if (op_sel == 3'b111) begin
      assert_slt_upper_clear_R5: assert (res[31:1] == 31'd0)
        else $error("compare result has upper bits set");
    end
    if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101) begin
      assert_unused_code_zero_R9: assert (res == 32'd0 && zero_flag)
        else $error("unused code produced a result");
    end
    if (!op_sel[2] && (opnd_a[31] != opnd_b[31])) begin
      assert_no_overflow_R7: assert (!ovf_flag)
        else $error("mixed-sign add reported overflow");
    end
    if (op_sel == 3'b110 && opnd_a == opnd_b) begin
      assert_equal_sub_zero_R4: assert (zero_flag && carry_out)
        else $error("equal operands did not subtract to zero");
    end
  end
endmodule

bind slice_alu slice_alu_checker u_checker (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_sel    (op_sel),
  .res       (res),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag),
  .carry_out (carry_out)
);

// File: tb/slice_alu_tb.sv
`timescale 1ns/1ps
module slice_alu_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] opnd_a, opnd_b, res;
  logic [2:0]  op_sel;
  logic        zero_flag, ovf_flag, carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  slice_alu u_dut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .res(res), .zero_flag(zero_flag), .ovf_flag(ovf_flag), .carry_out(carry_out)
  );

  function automatic logic [31:0] exp_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'b000: return a & b;                                   // R1
      3'b001: return a | b;                                   // R2
      3'b010: return a + b;                                   // R3
      3'b110: return a - b;                                   // R4
      3'b111: return {31'd0, ($signed(a) < $signed(b))};      // R5
      default: return 32'd0;                                  // R9
    endcase
  endfunction

  function automatic logic exp_carry(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    if (op[2]) return (a >= b);                               // R4 R10
    s = {1'b0, a} + {1'b0, b};
    return s[32];                                             // R3 R10
  endfunction

  function automatic logic exp_ovf(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    if (op[2]) begin
      r = a - b;
      return (a[31] != b[31]) && (r[31] != a[31]);            // R8
    end
    r = a + b;
    return (a[31] == b[31]) && (r[31] != a[31]);              // R7
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    er = exp_res(op, a, b);
    chk(req_of(op), "result", res, er);
    chk("R6", "zero", {31'd0, zero_flag}, {31'd0, (er == 32'd0)});
    chk(op[2] ? "R8" : "R7", "overflow", {31'd0, ovf_flag}, {31'd0, exp_ovf(op, a, b)});
    chk("R10", "carry", {31'd0, carry_out}, {31'd0, exp_carry(op, a, b)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [5];
    void'($urandom(32'd1234));
    op_sel = 3'b000; opnd_a = 32'd0; opnd_b = 32'd0;
    @(negedge clk);
    chk("R1", "idle result", res, 32'd0);
    chk("R6", "idle zero", {31'd0, zero_flag}, 32'd1);

    // Directed corners
    apply(3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF);      // R1
    apply(3'b001, 32'hF000_0001, 32'h000F_0010);      // R2
    apply(3'b010, 32'h7FFF_FFFF, 32'd2);              // R7 positive overflow
    apply(3'b010, 32'h8000_0001, 32'hFFFF_FFFE);      // R7 negative overflow, carry R3
    apply(3'b010, 32'h7FFF_FFFF, 32'h8000_0000);      // R7 mixed sign, no overflow
    apply(3'b010, 32'hFFFF_FFFF, 32'd1);              // R3 wraps to zero, carry
    apply(3'b110, 32'd7, 32'd6);                      // R4
    apply(3'b110, 32'd6, 32'd7);                      // R4 borrow
    apply(3'b110, 32'h1234_5678, 32'h1234_5678);      // R4 R6 equal
    apply(3'b110, 32'd0, 32'd0);                      // R4 carry on zero - zero
    apply(3'b110, 32'h8000_0000, 32'd1);              // R8 overflow
    apply(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);      // R8 overflow
    apply(3'b111, 32'h8000_0000, 32'd1);              // R5 overflowing compare
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);      // R5 overflowing compare
    apply(3'b111, 32'hFFFF_FFFF, 32'd0);              // R5 -1 < 0
    apply(3'b111, 32'd5, 32'd5);                      // R5 equal
    apply(3'b011, 32'hFFFF_FFFF, 32'h1234_5678);      // R9
    apply(3'b100, 32'hFFFF_FFFF, 32'h0000_0001);      // R9 R10
    apply(3'b101, 32'h0000_0000, 32'h8000_0000);      // R9 R10

    // Constrained random: mostly legal codes, edge-biased operands
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010;
    codes[3] = 3'b110; codes[4] = 3'b111;
    for (int k = 0; k < 3000; k++) begin
      logic [2:0]  op;
      logic [31:0] a, b;
      op = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : codes[$urandom_range(0, 4)];
      a  = $urandom;
      b  = $urandom;
      if ($urandom_range(0, 7) == 0) a = {a[31], {31{~a[31]}}};
      if ($urandom_range(0, 7) == 0) b = {b[31], {31{~b[31]}}};
      if ($urandom_range(0, 15) == 0) b = a;
      apply(op, a, b);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule